// File: doc/BRIEF.md
# Parallel Byte FIFO Bus Slave

This block lets an external controller move bytes in and out of a chip over an asynchronous 8-bit parallel bus. The controller reads with an active-low read strobe and writes with an active-high write strobe. Two active-low flags tell it when a byte is waiting to be read and when there is room for a byte to be written. Inside the chip, one small FIFO buffers the device-to-host stream and another buffers the host-to-device stream. The internal side of each FIFO is a plain valid/ready byte port.

Both strobes are asynchronous to the system clock. They pass through a multi-flop synchroniser, and every transfer is triggered by an edge detected in the system clock domain. The write data is delayed through a matching flop chain, so the byte that is stored is the one present when the strobe edge was sampled. The block drives the bus only while a read is in progress; at all other times the output enable is off. After each access, the matching flag is held inactive for a programmable number of system clocks, which gives the controller its recovery time.

Top module: `byte_bus_slave`

## Requirements
- R1: After reset, `bus_oe` is 0, `avail_n` is 1 (nothing to read) and `space_n` is 0 (room to write).
- R2: `avail_n` is 0 whenever the device-to-host FIFO holds at least one byte and no read recovery is running.
- R3: A falling edge of `rd_n` pops the oldest device-to-host byte onto `bus_out`, and `bus_oe` rises 3 clock cycles after that edge is driven. `bus_oe` returns to 0 3 cycles after `rd_n` rises. Bytes come out in the order they were pushed.
- R4: A read while the device-to-host FIFO is empty drives the last byte read again and removes nothing from the FIFO.
- R5: `space_n` is 0 while the host-to-device FIFO is not full and no write recovery is running. It stays 1 while that FIFO is full.
- R6: A high-to-low transition of `wr` stores the byte that is on `bus_in` into the host-to-device FIFO. The internal consumer receives the bytes in the order they were written.
- R7: A write that arrives while the host-to-device FIFO is full is dropped, and the FIFO contents are left unchanged.
- R8: `avail_n` is forced to 1 while `rd_n` is seen low and for `HOLD_CYC` cycles after the end of the read is detected. `space_n` is forced to 1 while `wr` is seen high and for `HOLD_CYC` cycles after the write edge.
- R9: A read and a write that overlap in time are both carried out, each with the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | DATA_W | Data bus value seen at the pad |
| bus_out | output | DATA_W | Byte driven onto the data bus during a read |
| bus_oe | output | 1 | Pad output enable for the data bus |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr | input | 1 | Write strobe; the transfer happens on its falling edge |
| avail_n | output | 1 | Low when a byte can be read |
| space_n | output | 1 | Low when a byte can be written |
| d2h_data | input | DATA_W | Device-to-host byte from the internal producer |
| d2h_valid | input | 1 | Producer offers `d2h_data` |
| d2h_ready | output | 1 | Device-to-host FIFO can take a byte |
| h2d_data | output | DATA_W | Oldest host-to-device byte |
| h2d_valid | output | 1 | Host-to-device FIFO holds a byte |
| h2d_ready | input | 1 | Consumer takes `h2d_data` |

## Verification
A host read and a host write can land in the same system clock cycle, because the two strobe synchronisers are independent and both FIFOs are updated on the same edge. The bench provokes this by lowering `rd_n` and raising `wr` on the same clock, then releasing both together. It judges the outcome in two places: the byte on the bus must match the front of the expected read queue, and the byte the consumer later pops must match the byte that was written. Both flags must also go through their recovery hold in that same window.

// File: rtl/bbs_pkg.sv
// Shared types for the parallel byte bus slave.
// Assumes: all users are clocked by the same system clock.
package bbs_pkg;
    // Synchronised strobe level plus single-cycle edge pulses.
    typedef struct packed {
        logic level;  // strobe level after the synchroniser
        logic rise;   // low-to-high transition seen this cycle
        logic fall;   // high-to-low transition seen this cycle
    } strobe_ev_t;
endpackage

// File: rtl/bbs_strobe_sync.sv
// Brings an asynchronous strobe into the clock domain and reports its edges.
// Assumes: the strobe stays at one level for longer than STAGES+1 clocks.
// IDLE_LVL is the level the strobe holds while no access is in progress.
module bbs_strobe_sync
    import bbs_pkg::*;
#(
    parameter int    STAGES   = 2,
    parameter logic  IDLE_LVL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_in,
    output strobe_ev_t ev
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchroniser chain plus one flop that keeps the previous synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{IDLE_LVL}};
            prev  <= IDLE_LVL;
        end else begin
            chain <= {chain[STAGES-2:0], strobe_in};
            prev  <= chain[STAGES-1];
        end
    end

    // Edge pulses, found by comparing the synced level with the previous one.
    always_comb begin
        ev.level = chain[STAGES-1];
        ev.rise  = ~prev & chain[STAGES-1];
        ev.fall  = prev & ~chain[STAGES-1];
    end
endmodule

// File: rtl/bbs_recovery_hold.sv
// Holds a flag inactive while an access is in progress and for HOLD_CYC
// clocks after the access ends. Assumes: done is a one-cycle pulse.
module bbs_recovery_hold #(
    parameter int HOLD_CYC = 4,
    localparam int CW      = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic done,
    output logic hold
);
    logic [CW-1:0] cnt;

    // Reload on the end-of-access pulse, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (done)           cnt <= CW'(HOLD_CYC);
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    // The flag is blocked during the access, on the end pulse, and while counting.
    assign hold = busy | done | (cnt != '0);

    p_hold_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> hold);
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(HOLD_CYC));
endmodule

// File: rtl/bbs_fifo.sv
// Small synchronous FIFO. A push while full and a pop while empty are ignored.
// Assumes: DEPTH is a power of two.
module bbs_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign head    = mem[rptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // Storage array; holds no reset so it can map to plain registers.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full && $stable(wptr));
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty && $stable(rptr));
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/byte_bus_slave.sv
// Asynchronous parallel byte bus slave. Strobe edges are synchronised and
// trigger FIFO transfers. The bus is driven only during a read, and each flag
// is held inactive for HOLD_CYC clocks after an access.
// Assumes: strobe pulses last longer than SYNC_STAGES+1 clocks, and write data
// is held from before the write strobe falls until after the edge is sampled.
module byte_bus_slave
    import bbs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FIFO_DEPTH  = 4,
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              rd_n,
    input  logic              wr,
    output logic              avail_n,
    output logic              space_n,
    input  logic [DATA_W-1:0] d2h_data,
    input  logic              d2h_valid,
    output logic              d2h_ready,
    output logic [DATA_W-1:0] h2d_data,
    output logic              h2d_valid,
    input  logic              h2d_ready
);
    strobe_ev_t        rd_ev, wr_ev;
    logic [DATA_W-1:0] wdata_pipe [SYNC_STAGES];
    logic [DATA_W-1:0] d2h_head;
    logic              d2h_full, d2h_empty, h2d_full, h2d_empty;
    logic              rd_hold, wr_hold;
    logic [DATA_W-1:0] out_q;
    logic              oe_q;

    bbs_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_in(rd_n), .ev(rd_ev));
    bbs_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b0)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_in(wr), .ev(wr_ev));

    // Delay the bus value as much as the write strobe, so both line up.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_wdata
            always_ff @(posedge clk) begin
                if (!rst_n)      wdata_pipe[s] <= '0;
                else if (s == 0) wdata_pipe[s] <= bus_in;
                else             wdata_pipe[s] <= wdata_pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    bbs_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_d2h (
        .clk(clk), .rst_n(rst_n),
        .push(d2h_valid), .push_data(d2h_data),
        .pop(rd_ev.fall), .head(d2h_head),
        .full(d2h_full), .empty(d2h_empty));

    bbs_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_h2d (
        .clk(clk), .rst_n(rst_n),
        .push(wr_ev.fall), .push_data(wdata_pipe[SYNC_STAGES-1]),
        .pop(h2d_ready), .head(h2d_data),
        .full(h2d_full), .empty(h2d_empty));

    // Read side: capture the popped byte and drive the bus while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            oe_q  <= 1'b0;
        end else begin
            if (rd_ev.fall && !d2h_empty) out_q <= d2h_head;
            oe_q <= ~rd_ev.level;
        end
    end

    bbs_recovery_hold #(.HOLD_CYC(HOLD_CYC)) u_rd_hold (
        .clk(clk), .rst_n(rst_n),
        .busy(~rd_ev.level), .done(rd_ev.rise), .hold(rd_hold));
    bbs_recovery_hold #(.HOLD_CYC(HOLD_CYC)) u_wr_hold (
        .clk(clk), .rst_n(rst_n),
        .busy(wr_ev.level), .done(wr_ev.fall), .hold(wr_hold));

    assign bus_out   = out_q;
    assign bus_oe    = oe_q;
    assign avail_n   = d2h_empty | rd_hold;
    assign space_n   = h2d_full | wr_hold;
    assign d2h_ready = ~d2h_full;
    assign h2d_valid = ~h2d_empty;

    p_bus_quiet_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> avail_n);
    p_read_end_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> avail_n);
    p_write_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ev.fall |=> space_n);
endmodule

// File: tb/test_byte_bus_slave.sv
module test_byte_bus_slave;
    localparam int DW = 8, DEPTH = 4, HOLD = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [DW-1:0] bus_in = '0, bus_out, d2h_data = '0, h2d_data;
    logic          bus_oe, rd_n = 1'b1, wr = 1'b0, avail_n, space_n;
    logic          d2h_valid = 1'b0, d2h_ready, h2d_valid, h2d_ready = 1'b0;

    int checks = 0, errors = 0;
    logic [DW-1:0] exp_rd[$];
    logic [DW-1:0] exp_wr[$];
    logic [DW-1:0] last_rd = '0;
    bit done = 0;

    always #4 clk = ~clk;

    byte_bus_slave #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .HOLD_CYC(HOLD)) i_byte_bus_slave (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .rd_n(rd_n), .wr(wr), .avail_n(avail_n), .space_n(space_n),
        .d2h_data(d2h_data), .d2h_valid(d2h_valid), .d2h_ready(d2h_ready),
        .h2d_data(h2d_data), .h2d_valid(h2d_valid), .h2d_ready(h2d_ready));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: the internal producer pushes a byte and records it as expected read data.
    task automatic dev_push(input logic [DW-1:0] b);
        chk(d2h_ready, "R2 producer ready", d2h_ready, 1);
        d2h_data = b; d2h_valid = 1'b1;
        step(1);
        d2h_valid = 1'b0;
        exp_rd.push_back(b);
    endtask

    // Monitor of one host read: compares the bus byte with the scoreboard front.
    task automatic host_read(input bit also_write, input logic [DW-1:0] wb);
        logic [DW-1:0] e;
        bit was_empty;
        was_empty = (exp_rd.size() == 0);
        e = was_empty ? last_rd : exp_rd.pop_front();
        rd_n = 1'b0;
        if (also_write) begin bus_in = wb; wr = 1'b1; end
        step(3);
        chk(bus_oe == 1'b1, "R3 bus driven during read", bus_oe, 1);
        chk(bus_out == e, was_empty ? "R4 empty read repeats last byte" : "R3 read data order",
            bus_out, e);
        chk(avail_n == 1'b1, "R8 avail_n high during read", avail_n, 1);
        step(4);
        rd_n = 1'b1;
        if (also_write) wr = 1'b0;
        last_rd = e;
        step(3);
        chk(bus_oe == 1'b0, "R3 bus released after read", bus_oe, 0);
        for (int k = 0; k < HOLD; k++) begin
            chk(avail_n == 1'b1, "R8 read recovery hold", avail_n, 1);
            step(1);
        end
        chk(avail_n == (exp_rd.size() == 0), "R2 avail_n after recovery", avail_n,
            int'(exp_rd.size() == 0));
        if (also_write && exp_wr.size() < DEPTH) exp_wr.push_back(wb);
    endtask

    // Driver: one host write; the byte is expected at the consumer unless the FIFO is full.
    task automatic host_write(input logic [DW-1:0] b);
        bus_in = b; wr = 1'b1;
        step(3);
        chk(space_n == 1'b1, "R8 space_n high during write", space_n, 1);
        step(4);
        wr = 1'b0;
        step(3);
        if (exp_wr.size() < DEPTH) exp_wr.push_back(b);
        for (int k = 0; k < HOLD; k++) begin
            chk(space_n == 1'b1, "R8 write recovery hold", space_n, 1);
            step(1);
        end
        chk(space_n == (exp_wr.size() == DEPTH), "R5 space_n after recovery", space_n,
            int'(exp_wr.size() == DEPTH));
    endtask

    // Monitor on the consumer side: pops and compares with the write scoreboard.
    task automatic drain_h2d();
        while (exp_wr.size() != 0) begin
            logic [DW-1:0] e;
            e = exp_wr.pop_front();
            chk(h2d_valid == 1'b1, "R6 consumer sees byte", h2d_valid, 1);
            chk(h2d_data == e, "R6 write data order", h2d_data, e);
            h2d_ready = 1'b1;
            step(1);
            h2d_ready = 1'b0;
        end
        chk(h2d_valid == 1'b0, "R7 no extra byte stored", h2d_valid, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(bus_oe == 1'b0, "R1 bus_oe after reset", bus_oe, 0);
        chk(avail_n == 1'b1, "R1 avail_n after reset", avail_n, 1);
        chk(space_n == 1'b0, "R1 space_n after reset", space_n, 0);

        // R2 / R3: three bytes pushed, then read back in order
        dev_push(8'hA1); dev_push(8'hB2); dev_push(8'hC3);
        chk(avail_n == 1'b0, "R2 avail_n low with data", avail_n, 0);
        host_read(1'b0, '0);
        host_read(1'b0, '0);
        host_read(1'b0, '0);
        chk(avail_n == 1'b1, "R2 avail_n high when empty", avail_n, 1);

        // R4: empty read repeats C3 and pops nothing; D4 is then read once
        host_read(1'b0, '0);
        dev_push(8'hD4);
        host_read(1'b0, '0);

        // R5 / R6 / R7: fill the write FIFO, then one write is dropped
        host_write(8'h11); host_write(8'h22); host_write(8'h33); host_write(8'h44);
        chk(space_n == 1'b1, "R5 space_n high when full", space_n, 1);
        host_write(8'h55);
        drain_h2d();
        step(1);
        chk(space_n == 1'b0, "R5 space_n low after drain", space_n, 0);

        // R9: overlapping read and write
        dev_push(8'hE5);
        host_read(1'b1, 8'h77);
        drain_h2d();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule